// File: doc/BRIEF.md
# Control Packet Builder

The block forms the outgoing control packets of a node that takes part in a distributed segment discovery protocol. Each packet has four fields: a packet kind, a segment identifier, a source node identifier and a time-to-live count. The node controller issues a command. The command names the kind, the output port, and whether the packet is newly created or forwarded. The block then assembles the fields and places the packet in a registered output slot. The slot hands the packet to the output buffer through a valid/ready handshake.

A newly created packet takes its source from the node's own identifier. Its segment identifier is the node identifier followed by the output port number. Its TTL starts at a fixed initial value. A forwarded packet keeps the segment and source of the copy held in the input buffer. Its TTL passes through unchanged, except when the packet is a cancel travelling back along a request path. In that case the TTL drops by one and stops at zero. A bootstrap node uses a fresh starting request as its first packet. The controller decides which packets to send; the builder only assembles them.

Top module: `ctrl_pkt_builder`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 until a command is accepted.
- R2: The packet kind is a 3-bit code: 0 starting request, 1 starting confirm, 2 segment request, 3 segment confirm, 4 segment cancel. An accepted command's kind appears unchanged on `out_kind`.
- R3: A fresh command (`cmd_fresh`=1) gives `out_src` = `node_id`, `out_seg` = {`node_id`, `cmd_port`} with the port in the low `PORT_W` bits, and `out_ttl` = `TTL_INIT` (7 by default).
- R4: A forwarded command (`cmd_fresh`=0) copies `in_seg` and `in_src`. For every kind other than cancel, it also copies `in_ttl`.
- R5: A forwarded cancel (kind 4) gives `out_ttl` = `in_ttl` - 1. An incoming TTL of 0 stays 0.
- R6: `ttl_expired` is 1 exactly when a valid packet is held with a TTL of 0.
- R7: While `out_valid`=1 and `out_ready`=0, every output packet field holds its value and `out_valid` stays 1.
- R8: `cmd_ready` = !`out_valid` | `out_ready`. An accepted command shows on the outputs, with `out_valid`=1, one clock after the edge that accepts it.
- R9: `out_port` carries the `cmd_port` of the accepted command.
- R10: A command whose kind code is 5, 6 or 7 produces no packet. When the slot is empty, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | NODE_W | This node's identifier |
| in_kind | input | 3 | Kind field of the input-buffer packet |
| in_seg | input | NODE_W+PORT_W | Segment field of the input-buffer packet |
| in_src | input | NODE_W | Source field of the input-buffer packet |
| in_ttl | input | TTL_W | TTL field of the input-buffer packet |
| cmd_valid | input | 1 | Controller command present |
| cmd_kind | input | 3 | Kind of packet to build |
| cmd_port | input | PORT_W | Output port for the packet |
| cmd_fresh | input | 1 | 1 = create new packet, 0 = forward |
| cmd_ready | output | 1 | Builder can take a command |
| out_valid | output | 1 | Output packet present |
| out_ready | input | 1 | Output buffer takes the packet |
| out_kind | output | 3 | Packet kind |
| out_seg | output | NODE_W+PORT_W | Segment identifier |
| out_src | output | NODE_W | Source node identifier |
| out_ttl | output | TTL_W | Time-to-live |
| out_port | output | PORT_W | Port the packet leaves on |
| ttl_expired | output | 1 | Held packet has TTL 0 |

## Verification
Every field result is due in the first cycle after the clock edge that accepts a command. The bench therefore drives each command on a falling edge and reads the packet at the next falling edge. `cmd_ready` depends only on present state and `out_ready`, so it is checked on the same falling edge that the command is driven. The bench sweeps all eight kind codes, both fresh and forwarded modes, all four ports and all eight incoming TTL values. Held outputs are checked on several falling edges in a row while `out_ready` is low.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_START_REQ  = 3'd0,
    KIND_START_CONF = 3'd1,
    KIND_SEG_REQ    = 3'd2,
    KIND_SEG_CONF   = 3'd3,
    KIND_SEG_CANCEL = 3'd4
  } pkt_kind_e;

  function automatic logic kind_is_legal(input logic [KIND_W-1:0] k);
    return k <= KIND_SEG_CANCEL;
  endfunction
endpackage

// File: rtl/cpb_field_sel.sv
module cpb_field_sel #(
  parameter int unsigned NODE_W = 4,
  parameter int unsigned PORT_W = 2,
  localparam int unsigned SEG_W = NODE_W + PORT_W
) (
  input  logic              fresh,
  input  logic [NODE_W-1:0] node_id,
  input  logic [PORT_W-1:0] port,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [NODE_W-1:0] in_src,
  output logic [SEG_W-1:0]  seg,
  output logic [NODE_W-1:0] src
);
  logic [SEG_W-1:0] own_seg;

  always_comb begin
    own_seg = {node_id, port};
    if (fresh) begin
      seg = own_seg;
      src = node_id;
    end else begin
      seg = in_seg;
      src = in_src;
    end
  end
endmodule

// File: rtl/cpb_ttl_calc.sv
module cpb_ttl_calc #(
  parameter int unsigned TTL_W    = 3,
  parameter int unsigned TTL_INIT = 7
) (
  input  logic             fresh,
  input  logic             is_cancel,
  input  logic [TTL_W-1:0] in_ttl,
  output logic [TTL_W-1:0] ttl
);
  localparam logic [TTL_W-1:0] INIT_V = TTL_W'(TTL_INIT);
  localparam logic [TTL_W-1:0] ONE_V  = TTL_W'(1);

  logic at_floor;

  always_comb begin
    at_floor = (in_ttl == '0);
    if (fresh) begin
      ttl = INIT_V;
    end else if (is_cancel) begin
      ttl = at_floor ? '0 : (in_ttl - ONE_V);
    end else begin
      ttl = in_ttl;
    end
  end
endmodule

// File: rtl/cpb_out_slot.sv
module cpb_out_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] d,
  output logic              vld,
  output logic [DATA_W-1:0] q
);
  logic              vld_nxt;
  logic              data_en;

  always_comb begin
    data_en = load;
    if (load) begin
      vld_nxt = 1'b1;
    end else if (drain) begin
      vld_nxt = 1'b0;
    end else begin
      vld_nxt = vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
    end else begin
      vld <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (data_en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/ctrl_pkt_builder.sv
module ctrl_pkt_builder
  import cpb_pkg::*;
#(
  parameter int unsigned NODE_W   = 4,
  parameter int unsigned PORT_W   = 2,
  parameter int unsigned TTL_W    = 3,
  parameter int unsigned TTL_INIT = 7,
  localparam int unsigned SEG_W   = NODE_W + PORT_W,
  localparam int unsigned PKT_W   = KIND_W + SEG_W + NODE_W + TTL_W + PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] node_id,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [NODE_W-1:0] in_src,
  input  logic [TTL_W-1:0]  in_ttl,
  input  logic              cmd_valid,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic              cmd_fresh,
  output logic              cmd_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KIND_W-1:0] out_kind,
  output logic [SEG_W-1:0]  out_seg,
  output logic [NODE_W-1:0] out_src,
  output logic [TTL_W-1:0]  out_ttl,
  output logic [PORT_W-1:0] out_port,
  output logic              ttl_expired
);
  logic [SEG_W-1:0]  sel_seg;
  logic [NODE_W-1:0] sel_src;
  logic [TTL_W-1:0]  sel_ttl;
  logic              is_cancel;
  logic              accept;
  logic [PKT_W-1:0]  pkt_d;
  logic [PKT_W-1:0]  pkt_q;
  logic              in_kind_unused;

  assign in_kind_unused = ^in_kind;

  cpb_field_sel #(.NODE_W(NODE_W), .PORT_W(PORT_W)) u_sel (
    .fresh   (cmd_fresh),
    .node_id (node_id),
    .port    (cmd_port),
    .in_seg  (in_seg),
    .in_src  (in_src),
    .seg     (sel_seg),
    .src     (sel_src)
  );

  cpb_ttl_calc #(.TTL_W(TTL_W), .TTL_INIT(TTL_INIT)) u_ttl (
    .fresh     (cmd_fresh),
    .is_cancel (is_cancel),
    .in_ttl    (in_ttl),
    .ttl       (sel_ttl)
  );

  always_comb begin
    is_cancel = (cmd_kind == KIND_SEG_CANCEL);
    cmd_ready = !out_valid || out_ready;
    accept    = cmd_valid && cmd_ready && kind_is_legal(cmd_kind);
    pkt_d     = {cmd_kind, sel_seg, sel_src, sel_ttl, cmd_port};
  end

  cpb_out_slot #(.DATA_W(PKT_W)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .drain (out_ready),
    .d     (pkt_d),
    .vld   (out_valid),
    .q     (pkt_q)
  );

  always_comb begin
    {out_kind, out_seg, out_src, out_ttl, out_port} = pkt_q;
    ttl_expired = out_valid && (out_ttl == '0);
  end
endmodule

// File: rtl/cpb_checker.sv
module cpb_checker #(
  parameter int unsigned NODE_W   = 4,
  parameter int unsigned PORT_W   = 2,
  parameter int unsigned TTL_W    = 3,
  parameter int unsigned TTL_INIT = 7,
  localparam int unsigned SEG_W   = NODE_W + PORT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODE_W-1:0] node_id,
  input logic [SEG_W-1:0]  in_seg,
  input logic [NODE_W-1:0] in_src,
  input logic [TTL_W-1:0]  in_ttl,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic [PORT_W-1:0] cmd_port,
  input logic              cmd_fresh,
  input logic              cmd_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_kind,
  input logic [SEG_W-1:0]  out_seg,
  input logic [NODE_W-1:0] out_src,
  input logic [TTL_W-1:0]  out_ttl,
  input logic [PORT_W-1:0] out_port,
  input logic              ttl_expired
);
  logic took;
  assign took = cmd_valid && cmd_ready && (cmd_kind <= 3'd4);

  p_legal_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind <= 3'd4));

  p_fresh_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_fresh) |=> (out_src == $past(node_id) && out_ttl == TTL_W'(TTL_INIT)));

  p_fwd_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !cmd_fresh) |=> (out_seg == $past(in_seg) && out_src == $past(in_src)));

  p_cancel_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !cmd_fresh && cmd_kind == 3'd4 && in_ttl != '0) |=>
      (out_ttl == $past(in_ttl) - TTL_W'(1)));

  p_expired_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ttl_expired |-> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_kind) && $stable(out_seg) && $stable(out_src)
       && $stable(out_ttl) && $stable(out_port)));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> (out_valid && out_port == $past(cmd_port)));

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(cmd_valid && cmd_kind <= 3'd4)) |=> !out_valid);
endmodule

bind ctrl_pkt_builder cpb_checker #(
  .NODE_W(NODE_W), .PORT_W(PORT_W), .TTL_W(TTL_W), .TTL_INIT(TTL_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .in_seg(in_seg), .in_src(in_src),
  .in_ttl(in_ttl), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_port(cmd_port),
  .cmd_fresh(cmd_fresh), .cmd_ready(cmd_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_seg(out_seg), .out_src(out_src),
  .out_ttl(out_ttl), .out_port(out_port), .ttl_expired(ttl_expired)
);

// File: tb/ctrl_pkt_builder_tb.sv
module ctrl_pkt_builder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] node_id;
  logic [2:0] in_kind;
  logic [5:0] in_seg;
  logic [3:0] in_src;
  logic [2:0] in_ttl;
  logic       cmd_valid;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_port;
  logic       cmd_fresh;
  logic       cmd_ready;
  logic       out_valid;
  logic       out_ready;
  logic [2:0] out_kind;
  logic [5:0] out_seg;
  logic [3:0] out_src;
  logic [2:0] out_ttl;
  logic [1:0] out_port;
  logic       ttl_expired;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ctrl_pkt_builder u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; node_id = 4'hA; in_kind = '0; in_seg = '0; in_src = '0; in_ttl = '0;
    cmd_valid = 1'b0; cmd_kind = '0; cmd_port = '0; cmd_fresh = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

    // Exhaustive sweep with the output buffer always ready
    for (int k = 0; k < 8; k++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 4; p++)
          for (int t = 0; t < 8; t++) begin
            int e_seg, e_src, e_ttl;
            cmd_kind = 3'(k); cmd_fresh = f[0]; cmd_port = 2'(p);
            in_ttl = 3'(t); in_seg = 6'((k * 7 + p * 5 + t) & 63); in_src = 4'((p * 3 + t) & 15);
            in_kind = 3'(k); cmd_valid = 1'b1;
            chk(cmd_ready == 1'b1, "R8", int'(cmd_ready), 1);
            if (f == 1) begin
              e_seg = 10 * 4 + p; e_src = 10; e_ttl = 7;
            end else begin
              e_seg = int'(in_seg); e_src = int'(in_src);
              e_ttl = (k == 4) ? ((t == 0) ? 0 : t - 1) : t;
            end
            @(negedge clk);
            cmd_valid = 1'b0;
            if (k > 4) begin
              chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
            end else begin
              chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
              chk(out_kind == 3'(k), "R2", int'(out_kind), k);
              chk(out_port == 2'(p), "R9", int'(out_port), p);
              chk(int'(out_seg) == e_seg, f ? "R3" : "R4", int'(out_seg), e_seg);
              chk(int'(out_src) == e_src, f ? "R3" : "R4", int'(out_src), e_src);
              chk(int'(out_ttl) == e_ttl, (f == 0 && k == 4) ? "R5" : (f ? "R3" : "R4"),
                  int'(out_ttl), e_ttl);
              chk(ttl_expired == (e_ttl == 0), "R6", int'(ttl_expired), int'(e_ttl == 0));
            end
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
          end

    // Backpressure: packet must hold while the buffer is not ready
    out_ready = 1'b0;
    cmd_kind = 3'd3; cmd_fresh = 1'b1; cmd_port = 2'd2; cmd_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
    cmd_kind = 3'd4; cmd_fresh = 1'b0; cmd_port = 2'd1; in_ttl = 3'd0; in_seg = 6'd9; in_src = 4'd3;
    for (int i = 0; i < 4; i++) begin
      chk(cmd_ready == 1'b0, "R8", int'(cmd_ready), 0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R7", int'(out_valid), 1);
      chk(out_kind == 3'd3, "R7", int'(out_kind), 3);
      chk(out_seg == 6'd42, "R7", int'(out_seg), 42);
      chk(out_port == 2'd2, "R7", int'(out_port), 2);
      chk(out_ttl == 3'd7, "R7", int'(out_ttl), 7);
    end
    out_ready = 1'b1;
    #0;
    chk(cmd_ready == 1'b1, "R8", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(out_kind == 3'd4, "R8", int'(out_kind), 4);
    chk(out_ttl == 3'd0, "R5", int'(out_ttl), 0);
    chk(ttl_expired == 1'b1, "R6", int'(ttl_expired), 1);
    chk(out_src == 4'd3, "R4", int'(out_src), 3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    chk(ttl_expired == 1'b0, "R6", int'(ttl_expired), 0);

    // Bootstrap: first packet is a fresh starting request
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    rst_n = 1'b1; node_id = 4'h5;
    cmd_kind = 3'd0; cmd_fresh = 1'b1; cmd_port = 2'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(out_seg == 6'd23, "R3", int'(out_seg), 23);
    chk(out_kind == 3'd0, "R2", int'(out_kind), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule